// File: doc/BRIEF.md
# Switchable-Depth Serial Receive Buffer

This block holds received bytes for a 16550-style serial port between the receiver (or its loopback path) and the data-register read path. It runs in one of two modes. In the first mode it is a single-byte holding register. In the second it is a 16-entry circular FIFO. Software picks the mode through writes to the FIFO control register. The block keeps a filtered copy of that register and exports it so that neighbouring logic can use the stored bits.

A byte is pushed whenever the receiver asserts `pushValid`. When the buffer already holds its full capacity, the push is refused and `overrun` pulses. The byte at the head is always shown on `popData`, and asserting `popReq` removes it. When the buffer is empty, the head reads as 0xFF. Any control write that switches the mode, or that enables the FIFO with the receiver-reset bit set, discards every stored byte.

Top module: `rx_switch_fifo`

## Requirements
- R1: After reset the stored control value is 0x00, count is 0, `notEmpty` is 0, `notFull` is 1, and the capacity is one byte.
- R2: Capacity is 1 byte while control bit 0 (enable) is clear and 16 bytes while it is set. `notFull` is low exactly when count equals the capacity.
- R3: A control write whose bit 0 differs from the stored bit 0 empties the buffer (count 0 after the write edge) and applies the new capacity.
- R4: A control write with bit 0 set and bit 1 (receiver reset) set empties the buffer and leaves the capacity at 16.
- R5: A control write with bit 0 clear stores 0x00, whatever its other bits are.
- R6: A control write with bit 0 set stores only bits 0, 3 (DMA mode), 6 and 7 (receive trigger) of the written value, that is the value AND 0xC9.
- R7: A push while count equals the capacity is dropped. `overrun` is high for exactly the one cycle after that edge, and the stored bytes and the count are unchanged.
- R8: With count 0, `popData` reads 0xFF, and a pop changes no state.
- R9: Bytes leave in the order they arrived, across pointer wraparound modulo the current capacity. The count equals pushes accepted minus pops accepted since the last flush.
- R10: A push and a pop in the same cycle on a buffer that is neither empty nor full both take effect, and the count stays the same.
- R11: In a cycle with a control write, any push or pop is ignored, and only the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Push strobe from receiver or loopback |
| pushData | input | 8 | Byte to push |
| popReq | input | 1 | Pop strobe from a data-register read |
| popData | output | 8 | Head byte, or 0xFF when empty |
| ctlWrite | input | 1 | FIFO control register write strobe |
| ctlData | input | 8 | FIFO control register write data |
| ctlValue | output | 8 | Stored (filtered) control register |
| count | output | 5 | Number of bytes held |
| notFull | output | 1 | Count below current capacity |
| notEmpty | output | 1 | Count above zero |
| overrun | output | 1 | One-cycle pulse after a refused push |

## Verification
On every cycle, the assertions check these behaviours:
- the capacity bound in each mode;
- the flush that follows a mode change or a receiver reset;
- the zero stored value after a disabling write;
- the overrun pulse with an unchanged count;
- the empty-pop no-op;
- pointers that stay inside the current capacity.

Only the bench's scenarios can show the following:
- the byte order across wraparound;
- that data survives a refused push;
- the exact 0xC9 filtering;
- that a control write takes priority over a push or pop in the same cycle.

The bench compares each of these against its own queue model over a long mixed push/pop sweep, and against hand-built mode-switch sequences.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int EnBit   = 0;
  localparam int RstBit  = 1;
  localparam logic [7:0] KeepMask = 8'hC9;

  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
    logic wide;
    logic hasData;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic               popReq,
  input  logic               ctlWrite,
  input  logic [7:0]         ctlData,
  output logic [7:0]         ctlValue,
  output logic [CNT_W-1:0]   count,
  output logic               notFull,
  output logic               notEmpty,
  output logic               overrun,
  output rxq_pkg::rxq_strobe_t stb
);
  import rxq_pkg::*;

  logic [7:0]       fcrReg;
  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] capacity;
  logic             fifoMode, full, doFlush, doPush, doPop, ovrReg;

  assign fifoMode = fcrReg[EnBit];
  assign capacity = fifoMode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (cntReg == capacity);
  assign doFlush  = ctlWrite && ((ctlData[EnBit] != fifoMode) ||
                                 (ctlData[EnBit] && ctlData[RstBit]));
  assign doPush   = pushValid && !ctlWrite && !full;
  assign doPop    = popReq && !ctlWrite && (cntReg != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fcrReg <= '0;
      cntReg <= '0;
      ovrReg <= 1'b0;
    end else begin
      ovrReg <= pushValid && !ctlWrite && full;
      if (ctlWrite)
        fcrReg <= ctlData[EnBit] ? (ctlData & KeepMask) : 8'h00;
      if (doFlush)
        cntReg <= '0;
      else if (doPush && !doPop)
        cntReg <= cntReg + CNT_W'(1);
      else if (doPop && !doPush)
        cntReg <= cntReg - CNT_W'(1);
    end
  end

  assign ctlValue = fcrReg;
  assign count    = cntReg;
  assign notFull  = !full;
  assign notEmpty = (cntReg != '0);
  assign overrun  = ovrReg;

  always_comb begin
    stb.flush   = doFlush;
    stb.push    = doPush;
    stb.pop     = doPop;
    stb.wide    = fifoMode;
    stb.hasData = (cntReg != '0);
  end

  p_single_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctlValue[0] |-> count <= CNT_W'(1));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_mode_flush_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && (ctlData[0] != ctlValue[0])) |=> count == '0);
  p_rx_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && ctlData[0] && ctlData[1]) |=> (count == '0 && ctlValue[0]));
  p_disable_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && !ctlData[0]) |=> ctlValue == 8'h00);
  p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !notFull && !popReq && !ctlWrite) |=> (overrun && $stable(count)));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !notEmpty && !pushValid && !ctlWrite) |=> (count == '0 && !overrun));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxq_pkg::rxq_strobe_t stb,
  input  logic [7:0]           pushData,
  output logic [7:0]           popData
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, lastIdx;

  assign lastIdx = stb.wide ? PTR_W'(DEPTH - 1) : '0;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (stb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr, lastIdx);
      if (stb.pop)  rdPtr <= bump(rdPtr, lastIdx);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= pushData;
  end

  assign popData = stb.hasData ? mem[rdPtr] : 8'hFF;

  p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr <= lastIdx) && (wrPtr <= lastIdx));
  p_flush_ptrs_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (rdPtr == '0 && wrPtr == '0));
endmodule

// File: rtl/rx_switch_fifo.sv
module rx_switch_fifo #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [7:0]       pushData,
  input  logic             popReq,
  output logic [7:0]       popData,
  input  logic             ctlWrite,
  input  logic [7:0]       ctlData,
  output logic [7:0]       ctlValue,
  output logic [CNT_W-1:0] count,
  output logic             notFull,
  output logic             notEmpty,
  output logic             overrun
);
  rxq_pkg::rxq_strobe_t stb;

  rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .ctlWrite(ctlWrite), .ctlData(ctlData), .ctlValue(ctlValue),
    .count(count), .notFull(notFull), .notEmpty(notEmpty),
    .overrun(overrun), .stb(stb));

  rxq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .pushData(pushData),
    .popData(popData));
endmodule

// File: tb/tb_rx_switch_fifo.sv
`timescale 1ns/1ps
module tb_rx_switch_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, popReq = 1'b0, ctlWrite = 1'b0;
  logic [7:0] pushData = '0, ctlData = '0;
  logic [7:0] popData, ctlValue;
  logic [4:0] count;
  logic notFull, notEmpty, overrun;

  int checks = 0;
  int fails = 0;
  logic [7:0] mq [16];
  int mn = 0;

  always #4 clk = ~clk;

  rx_switch_fifo dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .popData(popData), .ctlWrite(ctlWrite), .ctlData(ctlData),
    .ctlValue(ctlValue), .count(count), .notFull(notFull), .notEmpty(notEmpty),
    .overrun(overrun));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic step(input logic pv, input logic [7:0] pd, input logic pr,
                      input logic cw, input logic [7:0] cd);
    pushValid = pv; pushData = pd; popReq = pr; ctlWrite = cw; ctlData = cd;
    @(negedge clk);
    pushValid = 0; popReq = 0; ctlWrite = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctlValue", ctlValue, 0);
    chk("R1 count", count, 0);
    chk("R1 notEmpty", notEmpty, 0);
    chk("R1 notFull", notFull, 1);
    chk("R8 empty head", popData, 8'hFF);

    // R2 single-byte capacity
    step(1, 8'hA1, 0, 0, 0);
    chk("R2 count single", count, 1);
    chk("R2 notFull single", notFull, 0);
    chk("R2 head", popData, 8'hA1);
    // R7 refused push
    step(1, 8'hB2, 0, 0, 0);
    chk("R7 overrun pulse", overrun, 1);
    chk("R7 count kept", count, 1);
    chk("R7 data kept", popData, 8'hA1);
    step(0, 0, 0, 0, 0);
    chk("R7 pulse one cycle", overrun, 0);
    step(0, 0, 1, 0, 0);
    chk("R9 pop single", count, 0);
    // R8 pop empty
    step(0, 0, 1, 0, 0);
    chk("R8 count after empty pop", count, 0);
    chk("R8 head still FF", popData, 8'hFF);
    chk("R8 no overrun", overrun, 0);

    // R6 enable with all bits
    step(0, 0, 0, 1, 8'hFD);
    chk("R6 stored mask", ctlValue, 8'hC9);
    chk("R3 count after enable", count, 0);

    // R9/R10 sweep against queue model, capacity 16
    mn = 0;
    for (int i = 0; i < 400; i++) begin
      logic pv, pp, ovrExp, popped, pushed;
      logic [7:0] d;
      string tag;
      if (i < 200) begin
        pv = ((i * 7) % 5) < 3;
        pp = ((i * 11) % 7) < 3;
      end else begin
        pv = ((i * 7) % 5) < 2;
        pp = ((i * 13) % 9) < 5;
      end
      d = 8'(i) ^ 8'h5A;
      chk("R9 head order", popData, (mn > 0) ? int'(mq[0]) : 8'hFF);
      tag = (pv && pp && mn > 0 && mn < 16) ? "R10 push+pop count" : "R9 count";
      ovrExp = pv && (mn == 16);
      popped = pp && (mn > 0);
      pushed = pv && (mn < 16);
      step(pv, d, pp, 0, 0);
      if (popped) begin
        for (int k = 0; k < 15; k++) mq[k] = mq[k + 1];
        mn--;
      end
      if (pushed) begin
        mq[mn] = d;
        mn++;
      end
      chk(tag, count, mn);
      chk("R7 overrun sweep", overrun, ovrExp);
      chk("R2 notFull sweep", notFull, mn < 16);
    end

    // R10 dedicated
    step(0, 0, 0, 1, 8'h03);
    step(1, 8'h11, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0);
    step(1, 8'h33, 1, 0, 0);
    chk("R10 count unchanged", count, 2);
    chk("R10 head advanced", popData, 8'h22);

    // R4 receiver reset
    for (int k = 0; k < 5; k++) step(1, 8'(k), 0, 0, 0);
    step(0, 0, 0, 1, 8'h43);
    chk("R4 flushed", count, 0);
    chk("R4 stored", ctlValue, 8'h41);
    for (int k = 0; k < 16; k++) step(1, 8'(k + 8'h70), 0, 0, 0);
    chk("R4 capacity 16", count, 16);
    chk("R4 full flag", notFull, 0);
    chk("R4 head", popData, 8'h70);

    // R11 control write beats push/pop
    step(1, 8'hEE, 1, 1, 8'h01);
    chk("R11 count kept", count, 16);
    chk("R11 head kept", popData, 8'h70);
    chk("R11 no overrun", overrun, 0);

    // R3 disable flushes, R5 stored zero
    step(0, 0, 0, 1, 8'hC8);
    chk("R3 disable flush", count, 0);
    chk("R5 stored zero", ctlValue, 0);
    step(1, 8'h99, 0, 0, 0);
    step(1, 8'h98, 0, 0, 0);
    chk("R2 single after disable", count, 1);
    chk("R7 overrun after disable", overrun, 1);
    step(0, 0, 0, 1, 8'hFE);
    chk("R5 stored zero again", ctlValue, 0);
    chk("R5 no flush same mode", count, 1);
    chk("R5 data kept", popData, 8'h99);
    step(0, 0, 0, 1, 8'h09);
    chk("R3 enable flush", count, 0);
    chk("R6 stored DMA", ctlValue, 8'h09);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule